// File: doc/BRIEF.md
# Eight-Line Vectored Interrupt Controller

This block gathers eight interrupt request lines and presents one interrupt to the CPU. It resolves priority among pending, unmasked requests and returns a byte-wide vector through an acknowledge handshake. Software programs it through two byte-wide register ports on a simple synchronous bus. The command port is selected by `addr = 0` and the data port by `addr = 1`.

Before it raises any interrupt, software runs a short configuration sequence on these ports. After that, the data port holds the per-line mask. Command-port writes issue end-of-interrupt and priority-rotation commands, and they also choose which status register a command-port read returns. The controller keeps nested service in order: a line in service blocks every line of equal or lower priority until software, or the automatic end-of-interrupt mode, retires it. An acknowledge that finds no grantable request returns line 7's vector and changes nothing else. Software can recognise this case by reading the in-service register.

Top module: `intc8`

## Requirements
- R1: After reset, the mask is 0xFF, `int_out` and `vec_valid` are low, and the lowest-priority line is 7, so line 0 ranks highest. The controller stays unconfigured until a configuration sequence starts, and data-port writes made before that are ignored.
- R2: A command write with bit 4 = 1 starts configuration. In that word, bit 0 means a mode word follows and bit 3 selects level triggering. The write also clears the in-service and request registers, restores the default priority, selects the request register for reads, clears auto-EOI and re-arms the edge detectors, so a line already high must fall and rise again. The next data writes are taken as the vector base, then the cascade word, then the mode word (only if bit 0 was set). `int_out` stays low until the sequence ends. The cascade word reads back on the command port after a command write with bit 4 = 0, bit 3 = 1 and bit 2 = 1.
- R3: Once configured, every data-port write loads the mask, and a data-port read returns it. A set mask bit blocks its line from `int_out` but does not stop the line being recorded in the request register.
- R4: A one-cycle `ack` is answered in the next cycle with `vec_valid` high for one cycle and `vec_out` = base + granted line (modulo 256).
- R5: `int_out` is high when a pending, unmasked request outranks the highest-priority in-service line, or when nothing is in service. An acknowledge sets the in-service bit of the granted line, so each acknowledge adds at most one in-service bit.
- R6: A command write with bit 4 = 0, bit 3 = 1, bit 2 = 0 and bit 1 = 1 makes later command-port reads return the in-service register (bit 0 = 1) or the request register (bit 0 = 0). The choice persists until it is changed. Reads return data in the cycle after `rd_en`.
- R7: A command write with bit 4 = 0, bit 3 = 0 and bits 7:5 = 110 makes the line in bits 2:0 the lowest priority. For example, line 2 gives the order 3,4,5,6,7,0,1,2.
- R8: Command writes with bit 4 = 0 and bit 3 = 0 also retire in-service lines, selected by bits 7:5. With 001, the highest-priority in-service bit is cleared. With 101, that bit is cleared and its line becomes the lowest priority. With 011, the bit of the line in bits 2:0 is cleared. With 111, that bit is cleared and the same line becomes the lowest priority.
- R9: When mode-word bit 1 is set, an acknowledge returns the vector but leaves the in-service register unchanged.
- R10: In edge mode, a request bit is set by a rising input and cleared by its acknowledge or when the input falls, so an input held high after its acknowledge does not request again. In level mode, the request register follows the inputs with one cycle of delay, and an acknowledge does not clear it.
- R11: An acknowledge while no request is grantable returns base + 7 and leaves the in-service register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 1 | Port select: 0 command, 1 data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid the cycle after rd_en |
| irq_in | input | 8 | Interrupt request lines |
| int_out | output | 1 | Interrupt to the CPU |
| ack | input | 1 | One-cycle interrupt acknowledge |
| vec_out | output | 8 | Vector returned for the acknowledge |
| vec_valid | output | 1 | vec_out valid, one cycle after ack |

## Verification
On every cycle, the assertions check several properties. The interrupt output stays silent until configuration ends. A configured data write lands in the mask. Each acknowledge produces exactly one vector, and that vector falls inside the programmed eight-entry window. In-service bits only appear on an acknowledge and never more than one at a time. Spurious and auto-EOI acknowledges leave the in-service register untouched. The remaining behaviour needs the bench's scenarios, because it depends on exact values from programmed sequences: which line wins after a rotation, which bit each form of end-of-interrupt retires, the difference between edge and level re-requests, the read-register selection persisting, and the vectors produced for particular bases.

// File: rtl/intc8_pkg.sv
package intc8_pkg;
  localparam int N_LINES = 8;
  localparam int LINE_W  = $clog2(N_LINES);
  localparam int BYTE_W  = 8;

  typedef enum logic [2:0] {ST_UNINIT, ST_BASE, ST_CASC, ST_MODE, ST_READY} cfg_st_e;
  typedef enum logic [1:0] {RSEL_IRR, RSEL_ISR, RSEL_CASC} rsel_e;

  typedef struct packed {
    logic              hit;
    logic [LINE_W-1:0] line;
  } pick_t;

  // rank 0 is the highest priority; the line after "low" ranks first
  function automatic logic [LINE_W-1:0] rank_of(logic [LINE_W-1:0] line,
                                                logic [LINE_W-1:0] low);
    return LINE_W'(line - low - LINE_W'(1));
  endfunction

  function automatic pick_t find_top(logic [N_LINES-1:0] vec, logic [LINE_W-1:0] low);
    pick_t p;
    logic [LINE_W-1:0] ln;
    p = '0;
    for (int k = N_LINES - 1; k >= 0; k--) begin
      ln = LINE_W'(low + LINE_W'(k) + LINE_W'(1));
      if (vec[ln]) begin
        p.hit  = 1'b1;
        p.line = ln;
      end
    end
    return p;
  endfunction

  function automatic logic [N_LINES-1:0] line_bit(logic [LINE_W-1:0] ln);
    return N_LINES'(1) << ln;
  endfunction

  function automatic logic [BYTE_W-1:0] vec_calc(logic [BYTE_W-1:0] base,
                                                 logic [LINE_W-1:0] ln);
    return BYTE_W'(base + BYTE_W'(ln));
  endfunction
endpackage

// File: rtl/intc8_cfg.sv
module intc8_cfg
  import intc8_pkg::*;
#(
  parameter int DW = BYTE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_wr,
  input  logic          dat_wr,
  input  logic [DW-1:0] wdata,
  output logic          ready,
  output logic          init_pulse,
  output logic          imr_load,
  output logic          level_mode,
  output logic          aeoi,
  output logic [DW-1:0] base,
  output logic [DW-1:0] casc
);
  cfg_st_e st_q;
  logic    ic4_q;

  assign init_pulse = cmd_wr & wdata[4];
  assign ready      = (st_q == ST_READY);
  assign imr_load   = dat_wr & ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= ST_UNINIT;
      ic4_q      <= 1'b0;
      level_mode <= 1'b0;
      aeoi       <= 1'b0;
      base       <= '0;
      casc       <= '0;
    end else if (init_pulse) begin
      st_q       <= ST_BASE;
      ic4_q      <= wdata[0];
      level_mode <= wdata[3];
      aeoi       <= 1'b0;
    end else if (dat_wr) begin
      case (st_q)
        ST_BASE: begin
          base <= wdata;
          st_q <= ST_CASC;
        end
        ST_CASC: begin
          casc <= wdata;
          st_q <= ic4_q ? ST_MODE : ST_READY;
        end
        ST_MODE: begin
          aeoi <= wdata[1];
          st_q <= ST_READY;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/intc8_req.sv
module intc8_req
  import intc8_pkg::*;
#(
  parameter int NL = N_LINES
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          init_clr,
  input  logic          level_mode,
  input  logic [NL-1:0] irq_in,
  input  logic [NL-1:0] ack_clr,
  output logic [NL-1:0] irr
);
  for (genvar i = 0; i < NL; i++) begin : g_line
    logic prev_q;
    logic irr_q;
    always_ff @(posedge clk) begin
      if (!rst_n || init_clr) begin
        prev_q <= 1'b1;
        irr_q  <= 1'b0;
      end else begin
        prev_q <= irq_in[i];
        if (level_mode) irr_q <= irq_in[i];
        else            irr_q <= ((irr_q & ~ack_clr[i]) | (irq_in[i] & ~prev_q)) & irq_in[i];
      end
    end
    assign irr[i] = irr_q;
  end
endmodule

// File: rtl/intc8_prio.sv
module intc8_prio
  import intc8_pkg::*;
#(
  parameter int NL = N_LINES,
  parameter int LW = LINE_W
) (
  input  logic [NL-1:0] req,
  input  logic [NL-1:0] isr,
  input  logic [LW-1:0] low,
  output logic          grant,
  output logic [LW-1:0] grant_line,
  output logic          svc_hit,
  output logic [LW-1:0] svc_line
);
  pick_t req_pick, svc_pick;

  always_comb begin
    req_pick   = find_top(req, low);
    svc_pick   = find_top(isr, low);
    grant_line = req_pick.line;
    svc_hit    = svc_pick.hit;
    svc_line   = svc_pick.line;
    grant      = req_pick.hit &&
                 (!svc_pick.hit || (rank_of(req_pick.line, low) < rank_of(svc_pick.line, low)));
  end
endmodule

// File: rtl/intc8.sv
module intc8
  import intc8_pkg::*;
#(
  parameter int NL = N_LINES,
  parameter int LW = LINE_W,
  parameter int DW = BYTE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          addr,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic [NL-1:0] irq_in,
  output logic          int_out,
  input  logic          ack,
  output logic [DW-1:0] vec_out,
  output logic          vec_valid
);
  localparam logic [LW-1:0] LOW_DEFAULT = LW'(NL - 1);
  localparam logic [LW-1:0] SPUR_LINE   = LW'(NL - 1);

  logic          cmd_wr, dat_wr;
  logic          cfg_ready, init_pulse, imr_load, level_mode, aeoi_mode;
  logic [DW-1:0] vec_base, casc_word;
  logic [NL-1:0] irr, imr_q, isr_q, ack_clr, ack_set, eoi_clr;
  logic [LW-1:0] low_q, low_next, grant_line, svc_line;
  logic          grant, svc_hit;
  rsel_e         rsel_q;

  // decoded command events
  logic ocw2_wr, ocw3_wr, eoi_ns, eoi_sp, set_pri, ack_take;

  assign cmd_wr  = wr_en & ~addr;
  assign dat_wr  = wr_en & addr;
  assign ocw2_wr = cmd_wr & cfg_ready & ~wdata[4] & ~wdata[3];
  assign ocw3_wr = cmd_wr & cfg_ready & ~wdata[4] & wdata[3];
  assign eoi_ns  = ocw2_wr & wdata[5] & ~wdata[6];
  assign eoi_sp  = ocw2_wr & wdata[5] & wdata[6];
  assign set_pri = ocw2_wr & wdata[7] & wdata[6] & ~wdata[5];
  assign ack_take = ack & cfg_ready & grant;

  intc8_cfg #(.DW(DW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .dat_wr(dat_wr), .wdata(wdata),
    .ready(cfg_ready), .init_pulse(init_pulse), .imr_load(imr_load),
    .level_mode(level_mode), .aeoi(aeoi_mode), .base(vec_base), .casc(casc_word)
  );

  intc8_req #(.NL(NL)) u_req (
    .clk(clk), .rst_n(rst_n), .init_clr(init_pulse), .level_mode(level_mode),
    .irq_in(irq_in), .ack_clr(ack_clr), .irr(irr)
  );

  intc8_prio #(.NL(NL), .LW(LW)) u_prio (
    .req(irr & ~imr_q), .isr(isr_q), .low(low_q),
    .grant(grant), .grant_line(grant_line), .svc_hit(svc_hit), .svc_line(svc_line)
  );

  always_comb begin
    ack_set = (ack_take && !aeoi_mode) ? line_bit(grant_line) : '0;
    ack_clr = (ack_take && !level_mode) ? line_bit(grant_line) : '0;
    eoi_clr = '0;
    if (eoi_ns && svc_hit) eoi_clr = line_bit(svc_line);
    if (eoi_sp)            eoi_clr = line_bit(wdata[LW-1:0]);
    low_next = low_q;
    if (set_pri || (eoi_sp && wdata[7]))  low_next = wdata[LW-1:0];
    if (eoi_ns && wdata[7] && svc_hit)    low_next = svc_line;
  end

  assign int_out = cfg_ready & grant;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      imr_q     <= '1;
      isr_q     <= '0;
      low_q     <= LOW_DEFAULT;
      rsel_q    <= RSEL_IRR;
      rdata     <= '0;
      vec_out   <= '0;
      vec_valid <= 1'b0;
    end else begin
      if (init_pulse) begin
        isr_q  <= '0;
        low_q  <= LOW_DEFAULT;
        rsel_q <= RSEL_IRR;
      end else begin
        isr_q <= (isr_q & ~eoi_clr) | ack_set;
        low_q <= low_next;
        if (ocw3_wr) begin
          if (wdata[2])      rsel_q <= RSEL_CASC;
          else if (wdata[1]) rsel_q <= wdata[0] ? RSEL_ISR : RSEL_IRR;
        end
      end
      if (imr_load) imr_q <= wdata;
      if (rd_en) begin
        if (addr) rdata <= imr_q;
        else begin
          case (rsel_q)
            RSEL_ISR:  rdata <= isr_q;
            RSEL_CASC: rdata <= casc_word;
            default:   rdata <= irr;
          endcase
        end
      end
      vec_valid <= ack;
      if (ack) vec_out <= vec_calc(vec_base, ack_take ? grant_line : SPUR_LINE);
    end
  end
endmodule

// File: rtl/intc8_chk.sv
module intc8_chk #(
  parameter int NL = 8,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ack,
  input logic          wr_en,
  input logic          addr,
  input logic [DW-1:0] wdata,
  input logic          int_out,
  input logic          vec_valid,
  input logic [DW-1:0] vec_out,
  input logic          ready,
  input logic          aeoi,
  input logic [DW-1:0] base,
  input logic [NL-1:0] imr,
  input logic [NL-1:0] isr
);
  assert_quiet_until_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> !int_out);

  assert_mask_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && wr_en && addr) |=> (imr == $past(wdata)));

  assert_vec_after_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> vec_valid);

  assert_vec_only_on_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !ack |=> !vec_valid);

  assert_vec_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> (DW'(vec_out - $past(base)) < DW'(NL)));

  assert_one_new_isr_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> ($countones(isr & ~$past(isr)) <= 1));

  assert_isr_grows_on_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !ack |=> ((isr & ~$past(isr)) == '0));

  assert_spurious_keeps_isr_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !int_out && !wr_en) |=> (isr == $past(isr)));

  assert_auto_eoi_keeps_isr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && aeoi && !wr_en) |=> (isr == $past(isr)));
endmodule

bind intc8 intc8_chk #(.NL(NL), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ack(ack), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .int_out(int_out), .vec_valid(vec_valid), .vec_out(vec_out), .ready(cfg_ready),
  .aeoi(aeoi_mode), .base(vec_base), .imr(imr_q), .isr(isr_q)
);

// File: tb/intc8_bench.sv
module intc8_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       addr, wr_en, rd_en, ack;
  logic [7:0] wdata, rdata, irq_in, vec_out;
  logic       int_out, vec_valid;
  int         n_checks = 0;
  int         n_errors = 0;
  logic [7:0] rv;

  always #10 clk = ~clk;

  intc8 u_intc8 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .irq_in(irq_in), .int_out(int_out),
    .ack(ack), .vec_out(vec_out), .vec_valid(vec_valid)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic set_irq(input logic [7:0] v);
    @(negedge clk);
    irq_in = v;
    @(negedge clk);
  endtask

  task automatic do_ack(input string req, input logic [7:0] exp_vec);
    @(negedge clk);
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    chk(req, {7'd0, vec_valid}, 8'd1);
    chk(req, vec_out, exp_vec);
  endtask

  task automatic t_reset;
    chk("R1 int_out", {7'd0, int_out}, 8'd0);
    chk("R1 vec_valid", {7'd0, vec_valid}, 8'd0);
    rd(1'b1, rv); chk("R1 mask", rv, 8'hFF);
    wr(1'b1, 8'h00);
    rd(1'b1, rv); chk("R1 early data write ignored", rv, 8'hFF);
  endtask

  task automatic t_init;
    wr(1'b0, 8'h11); wr(1'b1, 8'h20); wr(1'b1, 8'h04); wr(1'b1, 8'h00);
    wr(1'b1, 8'h00);
    rd(1'b1, rv); chk("R3 mask load", rv, 8'h00);
    rd(1'b0, rv); chk("R6 default request read", rv, 8'h00);
    wr(1'b0, 8'h0C);
    rd(1'b0, rv); chk("R2 cascade readback", rv, 8'h04);
    wr(1'b0, 8'h0A);
  endtask

  task automatic t_nested;
    set_irq(8'h08); chk("R5 int on request", {7'd0, int_out}, 8'd1);
    do_ack("R4 vector line 3", 8'h23);
    chk("R10 edge held no re-request", {7'd0, int_out}, 8'd0);
    wr(1'b0, 8'h0B); rd(1'b0, rv); chk("R6 in-service read", rv, 8'h08);
    wr(1'b0, 8'h0A); rd(1'b0, rv); chk("R10 ack clears edge request", rv, 8'h00);
    wr(1'b0, 8'h0B);
    set_irq(8'h0A); chk("R5 higher nests", {7'd0, int_out}, 8'd1);
    do_ack("R4 vector line 1", 8'h21);
    rd(1'b0, rv); chk("R6 selection persists", rv, 8'h0A);
    set_irq(8'h2A); chk("R5 lower blocked", {7'd0, int_out}, 8'd0);
    wr(1'b0, 8'h20); rd(1'b0, rv); chk("R8 EOI clears top", rv, 8'h08);
    chk("R5 still blocked by 3", {7'd0, int_out}, 8'd0);
    wr(1'b0, 8'h20); rd(1'b0, rv); chk("R8 EOI clears next", rv, 8'h00);
    chk("R5 pending 5 released", {7'd0, int_out}, 8'd1);
    do_ack("R4 vector line 5", 8'h25);
    wr(1'b0, 8'h20);
    set_irq(8'h00);
    wr(1'b0, 8'h0A);
  endtask

  task automatic t_mask;
    wr(1'b1, 8'h10);
    set_irq(8'h10); chk("R3 masked line silent", {7'd0, int_out}, 8'd0);
    rd(1'b0, rv); chk("R3 masked line recorded", rv, 8'h10);
    wr(1'b1, 8'h00); chk("R3 unmask raises int", {7'd0, int_out}, 8'd1);
    do_ack("R4 vector line 4", 8'h24);
    wr(1'b0, 8'h20);
    set_irq(8'h00);
  endtask

  task automatic t_rotate;
    wr(1'b0, 8'hC2);
    set_irq(8'h12);
    do_ack("R7 line 4 outranks 1", 8'h24);
    chk("R7 line 1 below 4", {7'd0, int_out}, 8'd0);
    wr(1'b0, 8'h20); chk("R7 line 1 after EOI", {7'd0, int_out}, 8'd1);
    do_ack("R7 vector line 1", 8'h21);
    set_irq(8'h00);
    wr(1'b0, 8'hA0);
    wr(1'b0, 8'h0B); rd(1'b0, rv); chk("R8 rotate EOI clears", rv, 8'h00);
    wr(1'b0, 8'h0A);
    set_irq(8'h05);
    do_ack("R8 rotated order picks 2", 8'h22);
    wr(1'b0, 8'h20);
    do_ack("R8 then line 0", 8'h20);
    wr(1'b0, 8'h60);
    wr(1'b0, 8'h0B); rd(1'b0, rv); chk("R8 specific EOI", rv, 8'h00);
    wr(1'b0, 8'h0A);
    set_irq(8'h00);
    wr(1'b0, 8'hC7);
  endtask

  task automatic t_spurious;
    set_irq(8'h40); chk("R11 request seen", {7'd0, int_out}, 8'd1);
    set_irq(8'h00); chk("R11 request gone", {7'd0, int_out}, 8'd0);
    do_ack("R11 spurious vector", 8'h27);
    wr(1'b0, 8'h0B); rd(1'b0, rv); chk("R11 in-service untouched", rv, 8'h00);
    wr(1'b0, 8'h0A);
  endtask

  task automatic t_level;
    wr(1'b0, 8'h19); wr(1'b1, 8'h40); wr(1'b1, 8'h00); wr(1'b1, 8'h00);
    wr(1'b1, 8'h00);
    set_irq(8'h04); chk("R10 level request", {7'd0, int_out}, 8'd1);
    do_ack("R10 level vector", 8'h42);
    rd(1'b0, rv); chk("R10 level request kept", rv, 8'h04);
    wr(1'b0, 8'h20); chk("R10 level re-request", {7'd0, int_out}, 8'd1);
    do_ack("R10 level second vector", 8'h42);
    wr(1'b0, 8'h20);
    set_irq(8'h00); chk("R10 level follows input", {7'd0, int_out}, 8'd0);
    set_irq(8'h04);
    do_ack("R2 setup in-service", 8'h42);
  endtask

  task automatic t_aeoi;
    wr(1'b0, 8'h11); wr(1'b1, 8'h60); wr(1'b1, 8'h00); wr(1'b1, 8'h02);
    wr(1'b1, 8'h00);
    wr(1'b0, 8'h0B); rd(1'b0, rv); chk("R2 init clears in-service", rv, 8'h00);
    chk("R2 held line needs new edge", {7'd0, int_out}, 8'd0);
    set_irq(8'h00);
    set_irq(8'h20);
    do_ack("R9 auto-EOI vector", 8'h65);
    rd(1'b0, rv); chk("R9 no in-service bit", rv, 8'h00);
    set_irq(8'h24); chk("R9 lower line not blocked", {7'd0, int_out}, 8'd1);
    do_ack("R9 second vector", 8'h62);
    set_irq(8'h00);
  endtask

  task automatic t_no_ic4;
    wr(1'b0, 8'h10); wr(1'b1, 8'h80); wr(1'b1, 8'h00); wr(1'b1, 8'hF0);
    rd(1'b1, rv); chk("R2 short sequence then mask", rv, 8'hF0);
    wr(1'b1, 8'h00);
    set_irq(8'h01);
    do_ack("R2 base without mode word", 8'h80);
    wr(1'b0, 8'h0B); rd(1'b0, rv); chk("R2 auto-EOI cleared", rv, 8'h01);
  endtask

  initial begin
    rst_n = 1'b0; addr = 1'b0; wr_en = 1'b0; rd_en = 1'b0; ack = 1'b0;
    wdata = 8'h00; irq_in = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_init;
    t_nested;
    t_mask;
    t_rotate;
    t_spurious;
    t_level;
    t_aeoi;
    t_no_ic4;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule